// File: doc/BRIEF.md
# Command Buffer Flow Controller

This block steers one locality's command and response exchange through five states: idle, ready, reception, execution and completion. Software drives it through two kinds of write. A status write carries one of three request bits (command-ready, go, response-retry). A data write carries 1 to 4 bytes aimed at a byte lane of a 32-bit word. Command bytes are counted into a bounded write buffer. The block reads the command length from the header and decides from it when the command is whole.

When a whole command sees a go request, the block pulses a send request to the execution engine. It then waits for that engine's done input and reports the response as available. A command-ready request made during reception or execution raises an abort request. The abort request holds until the engine acknowledges it. The block's status flags (valid, data-available, expect, command-ready) and two one-cycle event pulses feed the register and interrupt logic around it.

Top module: `cmd_buf_fsm`

## Requirements
- R1: After reset, state is idle (code 0), all four flags are clear, the write offset is 0, and send_req, abort_req and both event outputs are low. State codes: idle 0, ready 1, reception 2, execution 3, completion 4.
- R2: Status and data writes whose wr_loc differs from active_loc change nothing.
- R3: A command-ready request in idle moves to ready, leaves only command-ready set and pulses ev_cmd_ready for one cycle. In ready it only clears the write offset.
- R4: A command-ready request in reception or execution raises abort_req. The request holds until abort_ack, during which status and data writes are ignored. On abort_ack the block goes to idle with offset 0 and all flags clear.
- R5: A command-ready request in completion moves to ready with offset 0, clears data-available, keeps valid, and sets command-ready with an ev_cmd_ready pulse when it was clear.
- R6: A go request in reception with expect clear moves to execution and pulses send_req for one cycle. In every other case a go request is ignored.
- R7: A response-retry request in completion leaves exactly valid and data-available set. In any other state it is ignored.
- R8: A status write with zero request bits, or with more than one, has no effect.
- R9: Data writes in idle, execution and completion are dropped. The first data write in ready moves to reception and leaves exactly expect and valid set.
- R10: A data write stores min(size, 4 - lane) bytes, taken from fifo_data[7:0] upward, one per offset. Bytes are stored only while expect is set.
- R11: The header length is the 32-bit value at buffer offsets 2 to 5, with offset 2 as the most significant byte. Once the offset exceeds 5 and expect is set, expect clears when the length is not larger than the offset.
- R12: A byte that arrives when the offset equals BUF_DEPTH is not stored, and it clears expect while valid stays set.
- R13: exec_done in execution moves to completion with offset 0, leaves exactly valid and data-available set, and pulses ev_data_avail for one cycle.
- R14: When a status write and a data write arrive in the same cycle, the data write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_loc | input | LOC_W | Locality that currently owns the interface |
| wr_loc | input | LOC_W | Locality issuing the current write |
| sts_wr | input | 1 | Status write strobe |
| req_cmd_ready | input | 1 | Command-ready request bit |
| req_go | input | 1 | Go request bit |
| req_retry | input | 1 | Response-retry request bit |
| fifo_wr | input | 1 | Data write strobe |
| fifo_lane | input | 2 | Starting byte lane of the data write |
| fifo_size | input | 3 | Requested byte count, 1 to 4 |
| fifo_data | input | 32 | Write bytes, first byte in bits 7:0 |
| exec_done | input | 1 | Execution engine reports a response |
| abort_ack | input | 1 | Execution engine acknowledges the abort |
| send_req | output | 1 | One-cycle pulse: hand the command to the engine |
| abort_req | output | 1 | Abort requested, held until acknowledged |
| flag_valid | output | 1 | Status-valid flag |
| flag_data_avail | output | 1 | Response-available flag |
| flag_expect | output | 1 | More command bytes expected |
| flag_cmd_ready | output | 1 | Ready to accept a command |
| ev_cmd_ready | output | 1 | One-cycle command-ready event |
| ev_data_avail | output | 1 | One-cycle data-available event |
| state | output | 3 | Current state code |
| wr_offset | output | OFF_W | Bytes stored in the write buffer |

## Verification
The bench builds the block with BUF_DEPTH set to 16 and LOC_W set to 2. With the small depth, four full-word writes fill the buffer. The overflow case, where a header announces 255 bytes and the block must drop the excess and clear expect, is then reached in a few cycles. A short header announcing 10 bytes, written with clipped and unaligned accesses, covers both outcomes of the length comparison well inside the same buffer.

// File: rtl/cmd_buf_fsm.sv
module cmd_buf_fsm #(
  parameter int BUF_DEPTH = 64,
  parameter int LOC_W = 3,
  localparam int OFF_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] active_loc,
  input  logic [LOC_W-1:0] wr_loc,
  input  logic             sts_wr,
  input  logic             req_cmd_ready,
  input  logic             req_go,
  input  logic             req_retry,
  input  logic             fifo_wr,
  input  logic [1:0]       fifo_lane,
  input  logic [2:0]       fifo_size,
  input  logic [31:0]      fifo_data,
  input  logic             exec_done,
  input  logic             abort_ack,
  output logic             send_req,
  output logic             abort_req,
  output logic             flag_valid,
  output logic             flag_data_avail,
  output logic             flag_expect,
  output logic             flag_cmd_ready,
  output logic             ev_cmd_ready,
  output logic             ev_data_avail,
  output logic [2:0]       state,
  output logic [OFF_W-1:0] wr_offset
);
  localparam logic [2:0] S_IDLE = 3'd0, S_READY = 3'd1, S_RECV = 3'd2,
                         S_EXEC = 3'd3, S_CMPL = 3'd4;

  logic             abort_pend;
  logic [31:0]      hdr_len;
  logic [2:0]       st_n;
  logic [OFF_W-1:0] off_n;
  logic [31:0]      len_n;
  logic             v_n, da_n, ex_n, cr_n, evc_n, evd_n, snd_n, ab_n;
  logic             owner;
  logic [2:0]       room, nbytes;
  logic [7:0]       byte_k;

  assign owner     = (wr_loc == active_loc) && !abort_pend;
  assign room      = 3'd4 - {1'b0, fifo_lane};
  assign nbytes    = (fifo_size > room) ? room : fifo_size;
  assign abort_req = abort_pend;

  always_comb begin
    st_n  = state;
    off_n = wr_offset;
    len_n = hdr_len;
    v_n   = flag_valid;
    da_n  = flag_data_avail;
    ex_n  = flag_expect;
    cr_n  = flag_cmd_ready;
    ab_n  = abort_pend;
    evc_n = 1'b0;
    evd_n = 1'b0;
    snd_n = 1'b0;
    byte_k = 8'h00;
    if (abort_pend && abort_ack) begin
      st_n = S_IDLE; off_n = '0; ab_n = 1'b0;
      {cr_n, ex_n, da_n, v_n} = 4'b0000;
    end else if (exec_done && state == S_EXEC) begin
      st_n = S_CMPL; off_n = '0; evd_n = 1'b1;
      {cr_n, ex_n, da_n, v_n} = 4'b0011;
    end else if (owner && sts_wr) begin
      case ({req_cmd_ready, req_go, req_retry})
        3'b100: begin
          case (state)
            S_READY: off_n = '0;
            S_IDLE: begin
              st_n = S_READY; evc_n = 1'b1;
              {cr_n, ex_n, da_n, v_n} = 4'b1000;
            end
            S_RECV, S_EXEC: ab_n = 1'b1;
            S_CMPL: begin
              st_n = S_READY; off_n = '0; da_n = 1'b0;
              if (!flag_cmd_ready) begin
                cr_n = 1'b1; evc_n = 1'b1;
              end
            end
            default: ;
          endcase
        end
        3'b010: begin
          if (state == S_RECV && !flag_expect) begin
            st_n = S_EXEC; snd_n = 1'b1;
          end
        end
        3'b001: begin
          if (state == S_CMPL) {cr_n, ex_n, da_n, v_n} = 4'b0011;
        end
        default: ;
      endcase
    end else if (owner && fifo_wr && (state == S_READY || state == S_RECV)) begin
      if (state == S_READY) begin
        st_n = S_RECV;
        {cr_n, ex_n, da_n, v_n} = 4'b0101;
      end
      for (int k = 0; k < 4; k++) begin
        if (k < int'(nbytes) && ex_n) begin
          if (int'(off_n) < BUF_DEPTH) begin
            byte_k = fifo_data[8*k +: 8];
            if (int'(off_n) == 2) len_n[31:24] = byte_k;
            if (int'(off_n) == 3) len_n[23:16] = byte_k;
            if (int'(off_n) == 4) len_n[15:8]  = byte_k;
            if (int'(off_n) == 5) len_n[7:0]   = byte_k;
            off_n = off_n + 1'b1;
          end else begin
            ex_n = 1'b0;
            v_n  = 1'b1;
          end
        end
      end
      if (int'(off_n) > 5 && ex_n) ex_n = (len_n > 32'(off_n));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      wr_offset <= '0;
      hdr_len <= '0;
      {flag_cmd_ready, flag_expect, flag_data_avail, flag_valid} <= 4'b0000;
      abort_pend <= 1'b0;
      ev_cmd_ready <= 1'b0;
      ev_data_avail <= 1'b0;
      send_req <= 1'b0;
    end else begin
      state <= st_n;
      wr_offset <= off_n;
      hdr_len <= len_n;
      {flag_cmd_ready, flag_expect, flag_data_avail, flag_valid} <= {cr_n, ex_n, da_n, v_n};
      abort_pend <= ab_n;
      ev_cmd_ready <= evc_n;
      ev_data_avail <= evd_n;
      send_req <= snd_n;
    end
  end
endmodule

// File: rtl/cmd_buf_fsm_chk.sv
module cmd_buf_fsm_chk #(
  parameter int BUF_DEPTH = 64,
  parameter int LOC_W = 3,
  localparam int OFF_W = $clog2(BUF_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LOC_W-1:0] active_loc,
  input logic [LOC_W-1:0] wr_loc,
  input logic             exec_done,
  input logic             abort_ack,
  input logic             send_req,
  input logic             abort_req,
  input logic             flag_valid,
  input logic             flag_data_avail,
  input logic             flag_expect,
  input logic             flag_cmd_ready,
  input logic             ev_cmd_ready,
  input logic             ev_data_avail,
  input logic [2:0]       state,
  input logic [OFF_W-1:0] wr_offset
);
  AST_SEND_FROM_RECEPTION: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |-> (state == 3'd3) && ($past(state) == 3'd2) && $past(!flag_expect)); // R6
  AST_EXPECT_IN_RECEPTION: assert property (@(posedge clk) disable iff (!rst_n)
    flag_expect |-> (state == 3'd2) && flag_valid); // R9
  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_offset) <= BUF_DEPTH); // R12
  AST_DONE_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_avail |-> (state == 3'd4) && flag_valid && flag_data_avail && (wr_offset == '0)); // R13
  AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req && !abort_ack |=> abort_req); // R4
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req && abort_ack |=> (state == 3'd0) && (wr_offset == '0) && !abort_req); // R4
  AST_CMD_READY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_ready |-> flag_cmd_ready && (state == 3'd1) && !flag_data_avail); // R3
  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_loc != active_loc) && !exec_done && !abort_ack |=>
      $stable(state) && $stable(wr_offset) && $stable(flag_expect) && $stable(flag_cmd_ready)); // R2
endmodule

bind cmd_buf_fsm cmd_buf_fsm_chk #(.BUF_DEPTH(BUF_DEPTH), .LOC_W(LOC_W)) u_chk (.*);

// File: tb/sim_cmd_buf_fsm.sv
module sim_cmd_buf_fsm;
  localparam int DEPTH = 16;
  localparam int LW = 2;
  localparam int OW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LW-1:0] active_loc = 2'd1, wr_loc = '0;
  logic sts_wr = 0, req_cmd_ready = 0, req_go = 0, req_retry = 0;
  logic fifo_wr = 0;
  logic [1:0] fifo_lane = '0;
  logic [2:0] fifo_size = '0;
  logic [31:0] fifo_data = '0;
  logic exec_done = 0, abort_ack = 0;
  logic send_req, abort_req, flag_valid, flag_data_avail, flag_expect, flag_cmd_ready;
  logic ev_cmd_ready, ev_data_avail;
  logic [2:0] state;
  logic [OW-1:0] wr_offset;

  always #5 clk = ~clk;

  cmd_buf_fsm #(.BUF_DEPTH(DEPTH), .LOC_W(LW)) u0 (.*);

  typedef struct {
    logic [2:0] st;
    logic [3:0] fl;
    int         off;
    logic [3:0] evs;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic compare(input exp_t e);
    logic [3:0] fl_a, ev_a;
    fl_a = {flag_cmd_ready, flag_expect, flag_data_avail, flag_valid};
    ev_a = {ev_cmd_ready, ev_data_avail, send_req, abort_req};
    checks++;
    if (state !== e.st || fl_a !== e.fl || int'(wr_offset) != e.off || ev_a !== e.evs) begin
      fails++;
      $display("FAIL %s: state=%0d flags=%b off=%0d ev=%b, expected state=%0d flags=%b off=%0d ev=%b",
               e.tag, state, fl_a, wr_offset, ev_a, e.st, e.fl, e.off, e.evs);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic clear_in();
    sts_wr = 0; req_cmd_ready = 0; req_go = 0; req_retry = 0;
    fifo_wr = 0; exec_done = 0; abort_ack = 0; wr_loc = active_loc;
  endtask

  task automatic chk(input logic [2:0] st, input logic [3:0] fl, input int off,
                     input logic [3:0] evs, input string tag);
    exp_t e;
    e.st = st; e.fl = fl; e.off = off; e.evs = evs; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1 clear_in();
  endtask

  task automatic sts(input logic [LW-1:0] loc, input logic c, input logic g, input logic r);
    @(negedge clk);
    wr_loc = loc; sts_wr = 1; req_cmd_ready = c; req_go = g; req_retry = r;
  endtask

  task automatic fifo(input logic [LW-1:0] loc, input logic [1:0] lane,
                      input logic [2:0] size, input logic [31:0] data);
    @(negedge clk);
    wr_loc = loc; fifo_wr = 1; fifo_lane = lane; fifo_size = size; fifo_data = data;
  endtask

  task automatic other(input logic d, input logic a);
    @(negedge clk);
    exec_done = d; abort_ack = a;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if (state !== 3'd0 || {flag_cmd_ready, flag_expect, flag_data_avail, flag_valid} !== 4'b0000 ||
        wr_offset !== '0 || {ev_cmd_ready, ev_data_avail, send_req, abort_req} !== 4'b0000) begin
      fails++;
      $display("FAIL R1: state=%0d off=%0d, expected reset values 0", state, wr_offset);
    end

    fifo(1, 0, 4, 32'h11223344);      chk(0, 4'b0000, 0, 4'b0000, "R9 idle data dropped");
    sts(2, 1, 0, 0);                  chk(0, 4'b0000, 0, 4'b0000, "R2 foreign status");
    sts(1, 1, 0, 0);                  chk(1, 4'b1000, 0, 4'b1000, "R3 idle to ready");
    sts(1, 0, 1, 0);                  chk(1, 4'b1000, 0, 4'b0000, "R6 go in ready");
    sts(1, 0, 0, 1);                  chk(1, 4'b1000, 0, 4'b0000, "R7 retry in ready");
    sts(1, 1, 1, 0);                  chk(1, 4'b1000, 0, 4'b0000, "R8 two request bits");
    sts(1, 0, 0, 0);                  chk(1, 4'b1000, 0, 4'b0000, "R8 no request bits");
    fifo(0, 0, 4, 32'h01020304);      chk(1, 4'b1000, 0, 4'b0000, "R2 foreign data");
    fifo(1, 3, 4, 32'h44332280);      chk(2, 4'b0101, 1, 4'b0000, "R10 lane clip to one byte");
    fifo(1, 0, 4, 32'h000000C1);      chk(2, 4'b0101, 5, 4'b0000, "R11 header bytes");
    fifo(1, 2, 2, 32'h0000110A);      chk(2, 4'b0101, 7, 4'b0000, "R11 length 10 above offset 7");
    sts(1, 0, 1, 0);                  chk(2, 4'b0101, 7, 4'b0000, "R6 go while expect set");
    @(negedge clk);
    wr_loc = 1; sts_wr = 1; req_retry = 1; fifo_wr = 1; fifo_lane = 0; fifo_size = 4;
    fifo_data = 32'hAABBCCDD;
    chk(2, 4'b0101, 7, 4'b0000, "R14 status beats data");
    fifo(1, 0, 3, 32'h00333322);      chk(2, 4'b0001, 10, 4'b0000, "R11 command complete");
    fifo(1, 0, 4, 32'h55555555);      chk(2, 4'b0001, 10, 4'b0000, "R10 no store with expect clear");
    sts(1, 0, 1, 0);                  chk(3, 4'b0001, 10, 4'b0010, "R6 go sends");
    fifo(1, 0, 4, 32'h66666666);      chk(3, 4'b0001, 10, 4'b0000, "R9 execution data dropped");
    other(1, 0);                      chk(4, 4'b0011, 0, 4'b0100, "R13 response done");
    sts(1, 0, 0, 1);                  chk(4, 4'b0011, 0, 4'b0000, "R7 retry in completion");
    sts(1, 0, 1, 0);                  chk(4, 4'b0011, 0, 4'b0000, "R6 go in completion");
    fifo(1, 0, 4, 32'h77777777);      chk(4, 4'b0011, 0, 4'b0000, "R9 completion data dropped");
    sts(1, 1, 0, 0);                  chk(1, 4'b1001, 0, 4'b1000, "R5 completion to ready");
    fifo(1, 0, 4, 32'h04030201);      chk(2, 4'b0101, 4, 4'b0000, "R9 first write enters reception");
    sts(1, 1, 0, 0);                  chk(2, 4'b0101, 4, 4'b0001, "R4 abort raised");
    fifo(1, 0, 4, 32'h08070605);      chk(2, 4'b0101, 4, 4'b0001, "R4 data ignored during abort");
    other(0, 0);                      chk(2, 4'b0101, 4, 4'b0001, "R4 abort held");
    other(0, 1);                      chk(0, 4'b0000, 0, 4'b0000, "R4 abort acknowledged");
    sts(1, 1, 0, 0);                  chk(1, 4'b1000, 0, 4'b1000, "R3 ready again");
    fifo(1, 0, 4, 32'h00000000);      chk(2, 4'b0101, 4, 4'b0000, "R10 full word");
    fifo(1, 0, 4, 32'h0000FF00);      chk(2, 4'b0101, 8, 4'b0000, "R11 length 255");
    fifo(1, 0, 4, 32'h00000000);      chk(2, 4'b0101, 12, 4'b0000, "R12 filling");
    fifo(1, 0, 4, 32'h00000000);      chk(2, 4'b0101, 16, 4'b0000, "R12 exactly full");
    fifo(1, 0, 4, 32'h00000000);      chk(2, 4'b0001, 16, 4'b0000, "R12 overflow clears expect");
    sts(1, 0, 1, 0);                  chk(3, 4'b0001, 16, 4'b0010, "R6 send after overflow");
    other(1, 0);                      chk(4, 4'b0011, 0, 4'b0100, "R13 second response");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule